// File: doc/BRIEF.md
# Load/Store Address Generator and Byte-Lane Aligner

This unit sits between a processor's register file and a 32-bit, byte-addressed memory bus. For each load or store request it computes the effective byte address from a base register value and an offset. The offset may be added or subtracted. Three indexing modes are supported. In plain offset mode the base is left alone. In pre-index writeback mode the sum is used as the address and is also returned as the new base. In post-index mode the unmodified base goes out as the address and the sum is returned as the new base.

The unit also moves data between the register's low bits and the correct byte lanes of the bus. Stores replicate narrow data across the bus and raise only the byte enables of the addressed bytes. Loads pull the addressed byte or halfword out of the returned bus word and zero-extend it. Lane placement follows a little- or big-endian mode taken from a pin while reset is asserted and frozen afterwards. Misaligned halfword and word accesses are flagged and never reach the bus.

All request results appear on registered outputs one clock after the request. Load data appears one clock after the memory's response strobe, using the lane context of the most recently issued load.

Top module: `ldst_unit`

## Requirements
- R1: While and directly after reset, bus_req, bus_we, misalign, wb_en and ld_valid are 0.
- R2: With idx_mode 0 (plain offset; code 3 behaves the same), bus_addr is base_val plus or minus offs_val and wb_en stays 0.
- R3: With idx_mode 1 (pre-index writeback), bus_addr and wb_val both equal the combined base and offset, and wb_en is 1 in the same cycle as bus_req.
- R4: With idx_mode 2 (post-index), bus_addr equals base_val unchanged, wb_val equals the combined base and offset, and wb_en is 1.
- R5: offs_sub = 1 subtracts offs_val from base_val; offs_sub = 0 adds it (modulo 2^32).
- R6: In little-endian mode (pin 0 at reset), the byte at address offset a = addr[1:0] uses bus_be bit a and data bits 8a+7:8a. A halfword at offset 0 uses bus_be 4'b0011 and at offset 2 uses 4'b1100. A word uses 4'b1111. req_size codes are 0 byte, 1 halfword, 2 word (3 behaves as word).
- R7: In big-endian mode (pin 1 at reset), the byte at offset a uses bus_be bit 3-a. A halfword at offset 0 uses 4'b1100 and at offset 2 uses 4'b0011.
- R8: Store data on bus_wdata is the low byte repeated four times for bytes, the low halfword repeated twice for halfwords, and st_data unchanged for words. bus_we is 1 only for stores.
- R9: One cycle after rsp_valid, ld_valid is 1 and ld_data holds the byte or halfword selected per R6/R7 from rsp_rdata, zero-extended, for the last issued load. Words are returned unchanged.
- R10: A halfword at an odd address, or a word whose address bits 1:0 are nonzero, sets misalign for one cycle with bus_req 0, bus_be 0 and wb_en 0.
- R11: Changes on endian_big_pin after reset has been released have no effect on lane placement.
- R12: All request outputs are registered: they reflect the request presented one clock earlier, and a cycle with req_valid 0 yields bus_req 0 and bus_be 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; endianness pin sampled while high |
| endian_big_pin | input | 1 | 1 selects big-endian lanes, latched during reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| idx_mode | input | 2 | 0 offset, 1 pre-index writeback, 2 post-index |
| offs_sub | input | 1 | 1 subtracts the offset |
| base_val | input | 32 | Base register value |
| offs_val | input | 32 | Offset (immediate or second register) |
| st_data | input | 32 | Register data to store |
| rsp_valid | input | 1 | Memory read data is valid |
| rsp_rdata | input | 32 | Memory read word |
| bus_req | output | 1 | Access issued on the bus |
| bus_we | output | 1 | Issued access is a write |
| bus_addr | output | 32 | Byte address |
| bus_be | output | 4 | Byte enables, one per lane |
| bus_wdata | output | 32 | Lane-steered store data |
| misalign | output | 1 | Request was suppressed as misaligned |
| wb_en | output | 1 | Base writeback strobe |
| wb_val | output | 32 | Updated base value |
| ld_valid | output | 1 | ld_data is valid |
| ld_data | output | 32 | Extracted, zero-extended load data |

## Verification
The assertions assume that inputs are stable around the clock edge and that req_valid and rsp_valid are low while reset is held. Under these assumptions, a look one cycle into the past pairs each output with the request that caused it. They also assume that a memory response only ever answers the latest issued load. The stimulus keeps within these limits: it changes inputs only on the falling edge and keeps both strobes low during reset. It presents rsp_valid only in the cycle after a load has been issued, with no other load in between, and it keeps the endianness pin steady through each reset pulse.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE_WB = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idx_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] offs_val,
  input  logic          offs_sub,
  input  logic [1:0]    idx_mode,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] new_base,
  output logic          wb_req
);
  logic [AW-1:0] combined;

  always_comb begin
    combined = offs_sub ? (base_val - offs_val) : (base_val + offs_val);
    new_base = combined;
    eff_addr = (idx_mode == IDX_POST) ? base_val : combined;
    wb_req   = (idx_mode == IDX_PRE_WB) || (idx_mode == IDX_POST);
  end
endmodule

// File: rtl/ldst_lane_map.sv
module ldst_lane_map
  import ldst_pkg::*;
#(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int LB = $clog2(NL)
) (
  input  logic [LB-1:0] lane_off,
  input  logic [1:0]    size,
  input  logic          big,
  output logic [NL-1:0] be,
  output logic          misalign
);
  logic [LB-1:0] byte_lane;

  assign byte_lane = lane_off ^ {LB{big}};
  assign misalign  = ((size == SZ_HALF) && lane_off[0]) ||
                     ((size == SZ_WORD || size == SZ_RSVD) && (lane_off != '0));

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam logic [LB-1:0] LID = LB'(i);
    assign be[i] = (size == SZ_BYTE) ? (byte_lane == LID) :
                   (size == SZ_HALF) ? ((byte_lane >> 1) == (LID >> 1)) :
                   1'b1;
  end
endmodule

// File: rtl/ldst_data_steer.sv
module ldst_data_steer
  import ldst_pkg::*;
#(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int LB = $clog2(NL)
) (
  input  logic [DW-1:0] st_data,
  input  logic [1:0]    st_size,
  input  logic [DW-1:0] rdata,
  input  logic [LB-1:0] ld_lane,
  input  logic [1:0]    ld_size,
  input  logic          big,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] ld_word
);
  logic [LB-1:0] ld_bl;
  logic [DW-1:0] byte_sh;
  logic [DW-1:0] half_sh;

  always_comb begin
    unique case (st_size)
      SZ_BYTE: wdata = {NL{st_data[7:0]}};
      SZ_HALF: wdata = {(NL/2){st_data[15:0]}};
      default: wdata = st_data;
    endcase
  end

  always_comb begin
    ld_bl   = ld_lane ^ {LB{big}};
    byte_sh = rdata >> {ld_bl, 3'b000};
    half_sh = rdata >> {ld_bl[LB-1:1], 4'b0000};
    unique case (ld_size)
      SZ_BYTE: ld_word = DW'(byte_sh[7:0]);
      SZ_HALF: ld_word = DW'(half_sh[15:0]);
      default: ld_word = rdata;
    endcase
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int LB = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          endian_big_pin,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [1:0]    req_size,
  input  logic [1:0]    idx_mode,
  input  logic          offs_sub,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] offs_val,
  input  logic [DW-1:0] st_data,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [NL-1:0] bus_be,
  output logic [DW-1:0] bus_wdata,
  output logic          misalign,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data
);
  logic          big_q;
  logic [LB-1:0] ctx_lane_q;
  logic [1:0]    ctx_size_q;

  logic [AW-1:0] eff_addr;
  logic [AW-1:0] new_base;
  logic          wb_req;
  logic [NL-1:0] lane_be;
  logic          mis_now;
  logic [DW-1:0] steered;
  logic [DW-1:0] ld_word;
  logic          issue;

  ldst_addr_gen #(.AW(AW)) u_addr (
    .base_val (base_val),
    .offs_val (offs_val),
    .offs_sub (offs_sub),
    .idx_mode (idx_mode),
    .eff_addr (eff_addr),
    .new_base (new_base),
    .wb_req   (wb_req)
  );

  ldst_lane_map #(.DW(DW)) u_lanes (
    .lane_off (eff_addr[LB-1:0]),
    .size     (req_size),
    .big      (big_q),
    .be       (lane_be),
    .misalign (mis_now)
  );

  ldst_data_steer #(.DW(DW)) u_steer (
    .st_data  (st_data),
    .st_size  (req_size),
    .rdata    (rsp_rdata),
    .ld_lane  (ctx_lane_q),
    .ld_size  (ctx_size_q),
    .big      (big_q),
    .wdata    (steered),
    .ld_word  (ld_word)
  );

  assign issue = req_valid && !mis_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      big_q      <= endian_big_pin;
      ctx_lane_q <= '0;
      ctx_size_q <= SZ_WORD;
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_be     <= '0;
      bus_wdata  <= '0;
      misalign   <= 1'b0;
      wb_en      <= 1'b0;
      wb_val     <= '0;
      ld_valid   <= 1'b0;
      ld_data    <= '0;
    end else begin
      bus_req   <= issue;
      bus_we    <= issue && req_store;
      bus_addr  <= eff_addr;
      bus_be    <= issue ? lane_be : '0;
      bus_wdata <= steered;
      misalign  <= req_valid && mis_now;
      wb_en     <= issue && wb_req;
      wb_val    <= new_base;
      ld_valid  <= rsp_valid;
      if (rsp_valid) ld_data <= ld_word;
      if (issue && !req_store) begin
        ctx_lane_q <= eff_addr[LB-1:0];
        ctx_size_q <= req_size;
      end
    end
  end
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NL = DW / 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [1:0]    req_size,
  input logic [1:0]    idx_mode,
  input logic [AW-1:0] base_val,
  input logic          rsp_valid,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [NL-1:0] bus_be,
  input logic          misalign,
  input logic          wb_en,
  input logic          ld_valid
);
  p_idle_no_lanes_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_req |-> bus_be == '0);

  p_req_needs_valid_r12: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> $past(req_valid));

  p_misalign_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (!bus_req && !wb_en));

  p_post_uses_base_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && $past(idx_mode) == 2'd2) |-> bus_addr == $past(base_val));

  p_byte_one_lane_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_req && $past(req_size) == 2'd0) |-> $countones(bus_be) == 1);

  p_wb_indexed_r3: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> ($past(idx_mode) == 2'd1 || $past(idx_mode) == 2'd2));

  p_write_is_access_r8: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> bus_req);

  p_ld_after_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(rsp_valid));
endmodule

bind ldst_unit ldst_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_size  (req_size),
  .idx_mode  (idx_mode),
  .base_val  (base_val),
  .rsp_valid (rsp_valid),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .misalign  (misalign),
  .wb_en     (wb_en),
  .ld_valid  (ld_valid)
);

// File: tb/test_ldst_unit.sv
module test_ldst_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        endian_big_pin = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [1:0]  idx_mode = 2'd0;
  logic        offs_sub = 1'b0;
  logic [31:0] base_val = '0;
  logic [31:0] offs_val = '0;
  logic [31:0] st_data = '0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        bus_req, bus_we, misalign, wb_en, ld_valid;
  logic [31:0] bus_addr, bus_wdata, wb_val, ld_data;
  logic [3:0]  bus_be;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string       tag;
    logic        req, we, mis, wb, ldv;
    logic [31:0] addr, wdata, wbval, ld;
    logic [3:0]  be;
  } item_t;

  item_t exp_q[$];

  logic        m_big = 1'b0;
  logic [1:0]  m_ctx_a = 2'd0;
  logic [1:0]  m_ctx_sz = 2'd2;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_unit i_ldst_unit (
    .clk(clk), .rst(rst), .endian_big_pin(endian_big_pin),
    .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
    .idx_mode(idx_mode), .offs_sub(offs_sub), .base_val(base_val),
    .offs_val(offs_val), .st_data(st_data), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .misalign(misalign), .wb_en(wb_en), .wb_val(wb_val),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] a, input logic big);
    if (sz == 2'd0) return 4'b0001 << (big ? (2'd3 - a) : a);
    if (sz == 2'd1) return ((big ? (a == 2'd0) : (a == 2'd2)) ? 4'b1100 : 4'b0011);
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_ld(input logic [31:0] rd, input logic [1:0] sz, input logic [1:0] a, input logic big);
    logic [1:0] lane;
    lane = big ? (2'd3 - a) : a;
    if (sz == 2'd0) return {24'h0, rd[8*lane +: 8]};
    if (sz == 2'd1) return ((big ? (a == 2'd0) : (a == 2'd2)) ? {16'h0, rd[31:16]} : {16'h0, rd[15:0]});
    return rd;
  endfunction

  // Driver: presents one cycle of stimulus and pushes the expected result.
  task automatic step(input string tag, input logic v, input logic st, input logic [1:0] sz,
                      input logic [1:0] md, input logic sb, input logic [31:0] b,
                      input logic [31:0] o, input logic [31:0] d,
                      input logic rv, input logic [31:0] rd);
    item_t it;
    logic [31:0] sum, ea;
    logic bad;
    @(negedge clk);
    req_valid = v; req_store = st; req_size = sz; idx_mode = md; offs_sub = sb;
    base_val = b; offs_val = o; st_data = d; rsp_valid = rv; rsp_rdata = rd;
    sum = sb ? (b - o) : (b + o);
    ea  = (md == 2'd2) ? b : sum;
    bad = ((sz == 2'd1) && ea[0]) || ((sz >= 2'd2) && (ea[1:0] != 2'd0));
    it.tag   = tag;
    it.mis   = v && bad;
    it.req   = v && !bad;
    it.we    = it.req && st;
    it.be    = it.req ? exp_be(sz, ea[1:0], m_big) : 4'b0000;
    it.addr  = ea;
    it.wdata = (sz == 2'd0) ? {4{d[7:0]}} : (sz == 2'd1) ? {2{d[15:0]}} : d;
    it.wb    = it.req && (md == 2'd1 || md == 2'd2);
    it.wbval = sum;
    it.ldv   = rv;
    it.ld    = exp_ld(rd, m_ctx_sz, m_ctx_a, m_big);
    if (it.req && !st) begin
      m_ctx_a = ea[1:0];
      m_ctx_sz = sz;
    end
    exp_q.push_back(it);
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst = 1'b1; endian_big_pin = pin; req_valid = 1'b0; rsp_valid = 1'b0;
    m_big = pin; m_ctx_a = 2'd0; m_ctx_sz = 2'd2;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "bus_req", {31'h0, bus_req}, 32'h0);
    chk("R1", "bus_we", {31'h0, bus_we}, 32'h0);
    chk("R1", "misalign", {31'h0, misalign}, 32'h0);
    chk("R1", "wb_en", {31'h0, wb_en}, 32'h0);
    chk("R1", "ld_valid", {31'h0, ld_valid}, 32'h0);
  endtask

  // Monitor: one expected item per clock, compared after the edge settles.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        item_t e;
        e = exp_q.pop_front();
        chk(e.tag, "bus_req", {31'h0, bus_req}, {31'h0, e.req});
        chk(e.tag, "misalign", {31'h0, misalign}, {31'h0, e.mis});
        chk(e.tag, "wb_en", {31'h0, wb_en}, {31'h0, e.wb});
        chk(e.tag, "bus_be", {28'h0, bus_be}, {28'h0, e.be});
        chk(e.tag, "ld_valid", {31'h0, ld_valid}, {31'h0, e.ldv});
        if (e.req) begin
          chk(e.tag, "bus_addr", bus_addr, e.addr);
          chk(e.tag, "bus_we", {31'h0, bus_we}, {31'h0, e.we});
        end
        if (e.we)  chk(e.tag, "bus_wdata", bus_wdata, e.wdata);
        if (e.wb)  chk(e.tag, "wb_val", wb_val, e.wbval);
        if (e.ldv) chk(e.tag, "ld_data", ld_data, e.ld);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Little-endian phase
    do_reset(1'b0);
    step("R2 offset word store", 1, 1, 2'd2, 2'd0, 0, 32'h1000, 32'h8, 32'hCAFEF00D, 0, 32'h0);
    step("R5 R6 sub byte load lane3", 1, 0, 2'd0, 2'd0, 1, 32'h2010, 32'hD, 32'h0, 0, 32'h0);
    step("R3 R6 R8 prewb half store", 1, 1, 2'd1, 2'd1, 0, 32'h100, 32'h2, 32'h0000BEEF, 0, 32'h0);
    step("R4 post word load", 1, 0, 2'd2, 2'd2, 0, 32'h3000, 32'h10, 32'h0, 0, 32'h0);
    step("R9 word load data", 0, 0, 2'd0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 1, 32'hA1B2C3D4);
    step("R6 byte load addr1", 1, 0, 2'd0, 2'd0, 0, 32'h400, 32'h1, 32'h0, 0, 32'h0);
    step("R9 byte zero-extend le", 0, 0, 2'd0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 1, 32'h11223344);
    step("R6 half load addr2", 1, 0, 2'd1, 2'd0, 0, 32'h400, 32'h2, 32'h0, 0, 32'h0);
    step("R9 half zero-extend le", 0, 0, 2'd0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 1, 32'h11223344);
    step("R8 byte store replicate", 1, 1, 2'd0, 2'd3, 0, 32'h600, 32'h2, 32'h123456A5, 0, 32'h0);
    step("R10 odd half prewb", 1, 1, 2'd1, 2'd1, 0, 32'h400, 32'h3, 32'h0, 0, 32'h0);
    step("R10 word post base 0x502", 1, 0, 2'd2, 2'd2, 0, 32'h502, 32'h2, 32'h0, 0, 32'h0);
    step("R12 idle cycle", 0, 1, 2'd2, 2'd1, 0, 32'h0, 32'h0, 32'h0, 0, 32'h0);
    step("R5 R4 post sub wrap", 1, 1, 2'd2, 2'd2, 1, 32'h4, 32'h8, 32'h55, 0, 32'h0);
    // R11: pin toggled without reset must not change lane order
    @(negedge clk);
    endian_big_pin = 1'b1;
    step("R11 pin change ignored", 1, 1, 2'd0, 2'd0, 0, 32'h700, 32'h1, 32'h77, 0, 32'h0);
    step("R11 drain", 0, 0, 2'd0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 0, 32'h0);
    repeat (2) @(negedge clk);

    // Big-endian phase
    do_reset(1'b1);
    step("R7 byte store addr0", 1, 1, 2'd0, 2'd0, 0, 32'h800, 32'h0, 32'h9A, 0, 32'h0);
    step("R7 half store addr2", 1, 1, 2'd1, 2'd1, 0, 32'h800, 32'h2, 32'h1357, 0, 32'h0);
    step("R7 byte load addr2", 1, 0, 2'd0, 2'd0, 0, 32'h900, 32'h2, 32'h0, 0, 32'h0);
    step("R9 byte zero-extend be", 0, 0, 2'd0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 1, 32'h11223344);
    step("R7 half load addr0", 1, 0, 2'd1, 2'd2, 0, 32'h904, 32'h2, 32'h0, 0, 32'h0);
    step("R9 half zero-extend be", 0, 0, 2'd0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 1, 32'h11223344);
    step("R7 word store be", 1, 1, 2'd2, 2'd0, 0, 32'hA00, 32'h4, 32'hDEADBEEF, 0, 32'h0);
    step("R12 final idle", 0, 0, 2'd0, 2'd0, 0, 32'h0, 32'h0, 32'h0, 0, 32'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule